// File: doc/BRIEF.md
# Burst Column Address Generator

This block sits beside the column path of a synchronous DRAM device. When a column command is accepted it receives the first column of the burst and the burst settings held in the mode register. It then produces one column address per clock, one for each data beat, until the burst is complete or is cut short. Two orderings are supported. Sequential ordering counts upward and wraps inside the aligned block. Interleaved ordering XORs the beat number into the low address bits. The burst can be 1, 2, 4 or 8 beats long, or it can run over a whole page. A whole-page burst cycles through every column and has no natural end.

A new column command can arrive on any clock. It replaces any burst in progress, so back-to-back commands give an unbroken stream of beats. A terminate input stops a burst. If the single-write option is set, every write is one beat and reads keep the programmed length. A length code that has no meaning, for the selected ordering, gives a one-beat burst and raises a configuration error flag.

Top module: `burst_colgen`

## Requirements
- R1: A start on a clock edge makes `beat_vld_o` high from the next edge, with `col_o` equal to the start column on that first beat.
- R2: Length codes 000, 001, 010 and 011 give bursts of 1, 2, 4 and 8 beats. `last_o` is high on the final beat only, and `beat_vld_o` falls on the edge after that beat unless a new start arrives.
- R3: With `order_i`=0 (sequential), beat k has column `(start & ~(L-1)) | ((start + k) & (L-1))` for burst length L. The bits above the burst length stay fixed and the low bits wrap.
- R4: With `order_i`=1 (interleaved), beat k has column `start ^ k` for k < L.
- R5: Code 111 with sequential ordering is a whole-page burst. The column goes up by one per beat, modulo 2^COL_W, and wraps past the top. `last_o` is never asserted, and the burst continues until it is stopped or restarted.
- R6: Codes 100, 101 and 110, and code 111 with interleaved ordering, are reserved. Each gives a one-beat burst at the start column. `cfg_err_o` goes high from the edge after that start and stays high until the next start with a valid code.
- R7: When `single_wr_i`=1 and `is_write_i`=1, the burst is one beat whatever the length code. A read with `single_wr_i`=1, or a write with `single_wr_i`=0, uses the programmed length.
- R8: `stop_i` without `start_i` clears `beat_vld_o` on the next edge. If `start_i` and `stop_i` are high together, the start wins.
- R9: A start during a burst drops the old burst and begins the new one on the next edge. A start on every clock gives one valid beat per clock.
- R10: During reset and right after it, `beat_vld_o`, `last_o`, `cfg_err_o` and `col_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Column command accepted this cycle |
| start_col_i | input | COL_W | First column of the burst |
| len_code_i | input | 3 | Burst length code |
| order_i | input | 1 | 0 sequential, 1 interleaved |
| is_write_i | input | 1 | Command is a write |
| single_wr_i | input | 1 | Single-write option: writes are one beat |
| stop_i | input | 1 | Terminate the current burst |
| col_o | output | COL_W | Column of the current beat |
| beat_vld_o | output | 1 | A burst beat is present this cycle |
| last_o | output | 1 | Current beat is the last one of a finite burst |
| cfg_err_o | output | 1 | Last start used a reserved length code |

## Verification
The vector table uses start columns that sit in the middle of an aligned block, so that sequential wrap and interleaved XOR produce different orders. Several of these start columns have high bits set, so an address map that leaks a carry past the block boundary is exposed. The same length code is applied as a read, as a burst write and as a single write, which separates the write override from the length decode. Directed cases start a whole-page burst near the top column so that the modulo wrap shows. They also stop and restart bursts partway through, and issue a one-beat start on every clock.

// File: rtl/burst_colgen_pkg.sv
package burst_colgen_pkg;

   localparam int unsigned LEN_CODE_W = 3;

   localparam logic [LEN_CODE_W-1:0] LC_ONE  = 3'b000;
   localparam logic [LEN_CODE_W-1:0] LC_TWO  = 3'b001;
   localparam logic [LEN_CODE_W-1:0] LC_FOUR = 3'b010;
   localparam logic [LEN_CODE_W-1:0] LC_EIGHT = 3'b011;
   localparam logic [LEN_CODE_W-1:0] LC_PAGE = 3'b111;

   // decoded burst shape
   typedef struct packed {
      logic       page;    // endless whole-page burst
      logic [1:0] lg;      // log2 of finite length
      logic       bad;     // reserved code seen
   } len_dec_t;

endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode
   import burst_colgen_pkg::*;
(
   input  logic [LEN_CODE_W-1:0] code_i,
   input  logic                  intl_i,
   input  logic                  is_write_i,
   input  logic                  single_wr_i,
   output len_dec_t              dec_o
);

   len_dec_t raw;

   always_comb begin
      raw = '0;
      unique case (code_i)
         LC_ONE:   raw.lg = 2'd0;
         LC_TWO:   raw.lg = 2'd1;
         LC_FOUR:  raw.lg = 2'd2;
         LC_EIGHT: raw.lg = 2'd3;
         LC_PAGE: begin
            // whole page exists only for the counting order
            if (intl_i) raw.bad  = 1'b1;
            else        raw.page = 1'b1;
         end
         default:  raw.bad = 1'b1;
      endcase
   end

   always_comb begin
      dec_o = raw;
      if (is_write_i && single_wr_i) begin
         dec_o.page = 1'b0;
         dec_o.lg   = 2'd0;
      end
   end

endmodule

// File: rtl/burst_beat_counter.sv
module burst_beat_counter
   import burst_colgen_pkg::*;
#(
   parameter int unsigned COL_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             stop_i,
   input  logic [COL_W-1:0] start_col_i,
   input  logic             intl_i,
   input  len_dec_t         dec_i,
   output logic             active_o,
   output logic             last_o,
   output logic             page_o,
   output logic             intl_o,
   output logic             err_o,
   output logic [COL_W-1:0] base_o,
   output logic [COL_W-1:0] cnt_o,
   output logic [COL_W-1:0] mask_o
);

   logic [COL_W-1:0] mask_d;
   logic             active_q, page_q, intl_q, err_q;
   logic [COL_W-1:0] base_q, cnt_q, mask_q;
   logic             at_end;

   always_comb begin
      if (dec_i.page) mask_d = {COL_W{1'b1}};
      else            mask_d = ~({COL_W{1'b1}} << dec_i.lg);
   end

   assign at_end = active_q && !page_q && (cnt_q == mask_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         page_q   <= 1'b0;
         intl_q   <= 1'b0;
         err_q    <= 1'b0;
         base_q   <= '0;
         cnt_q    <= '0;
         mask_q   <= '0;
      end else if (start_i) begin
         active_q <= 1'b1;
         page_q   <= dec_i.page;
         intl_q   <= intl_i;
         err_q    <= dec_i.bad;
         base_q   <= start_col_i;
         cnt_q    <= '0;
         mask_q   <= mask_d;
      end else if (stop_i) begin
         active_q <= 1'b0;
      end else if (active_q) begin
         if (at_end) active_q <= 1'b0;
         else        cnt_q    <= cnt_q + 1'b1;
      end
   end

   assign active_o = active_q;
   assign last_o   = at_end;
   assign page_o   = page_q;
   assign intl_o   = intl_q;
   assign err_o    = err_q;
   assign base_o   = base_q;
   assign cnt_o    = cnt_q;
   assign mask_o   = mask_q;

   // R5: a whole-page burst keeps running when left alone
   assert_page_runs_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && page_q && !start_i && !stop_i) |=> active_q);

   // R2: the beat count of a finite burst never passes its mask
   assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && !page_q) |-> ((cnt_q & ~mask_q) == '0));

endmodule

// File: rtl/burst_addr_map.sv
module burst_addr_map #(
   parameter int unsigned COL_W = 8
) (
   input  logic [COL_W-1:0] base_i,
   input  logic [COL_W-1:0] cnt_i,
   input  logic [COL_W-1:0] mask_i,
   input  logic             intl_i,
   output logic [COL_W-1:0] col_o
);

   logic [COL_W-1:0] sum;
   assign sum = base_i + cnt_i;

   for (genvar b = 0; b < COL_W; b++) begin : g_bit
      logic seq_bit, xor_bit;
      assign seq_bit  = mask_i[b] ? sum[b] : base_i[b];
      assign xor_bit  = base_i[b] ^ (cnt_i[b] & mask_i[b]);
      assign col_o[b] = intl_i ? xor_bit : seq_bit;
   end

endmodule

// File: rtl/burst_colgen.sv
module burst_colgen
   import burst_colgen_pkg::*;
#(
   parameter int unsigned COL_W = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start_i,
   input  logic [COL_W-1:0]      start_col_i,
   input  logic [LEN_CODE_W-1:0] len_code_i,
   input  logic                  order_i,
   input  logic                  is_write_i,
   input  logic                  single_wr_i,
   input  logic                  stop_i,
   output logic [COL_W-1:0]      col_o,
   output logic                  beat_vld_o,
   output logic                  last_o,
   output logic                  cfg_err_o
);

   if (COL_W < 3 || COL_W > 16) begin : g_bad_width
      $error("burst_colgen: COL_W must lie in 3..16");
   end

   len_dec_t         dec;
   logic             page_q, intl_q;
   logic [COL_W-1:0] base_q, cnt_q, mask_q;

   burst_len_decode u_dec (
      .code_i      (len_code_i),
      .intl_i      (order_i),
      .is_write_i  (is_write_i),
      .single_wr_i (single_wr_i),
      .dec_o       (dec)
   );

   burst_beat_counter #(.COL_W(COL_W)) u_cnt (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .stop_i      (stop_i),
      .start_col_i (start_col_i),
      .intl_i      (order_i),
      .dec_i       (dec),
      .active_o    (beat_vld_o),
      .last_o      (last_o),
      .page_o      (page_q),
      .intl_o      (intl_q),
      .err_o       (cfg_err_o),
      .base_o      (base_q),
      .cnt_o       (cnt_q),
      .mask_o      (mask_q)
   );

   burst_addr_map #(.COL_W(COL_W)) u_map (
      .base_i (base_q),
      .cnt_i  (cnt_q),
      .mask_i (mask_q),
      .intl_i (intl_q),
      .col_o  (col_o)
   );

   assert_start_first_beat_R1: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (beat_vld_o && col_o == $past(start_col_i)));

   assert_last_in_burst_R2: assert property (@(posedge clk) disable iff (!rst_n)
      last_o |-> beat_vld_o);

   assert_end_after_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (last_o && !start_i) |=> !beat_vld_o);

   // R3 and R4: only bits inside the burst window may move between beats
   assert_high_bits_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_vld_o && !start_i && !stop_i && !last_o) |=>
         (((col_o ^ $past(col_o)) & ~mask_q) == '0));

   assert_reserved_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && (len_code_i inside {3'b100, 3'b101, 3'b110} ||
                   (len_code_i == 3'b111 && order_i))) |=> (cfg_err_o && last_o));

   assert_single_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && is_write_i && single_wr_i) |=> last_o);

   assert_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_i && !start_i) |=> !beat_vld_o);

   assert_page_never_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
      page_q |-> !last_o);

endmodule

// File: tb/burst_colgen_tb_top.sv
`timescale 1ns/1ps
module burst_colgen_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic [7:0] start_col_i = '0;
   logic [2:0] len_code_i = '0;
   logic       order_i = 1'b0;
   logic       is_write_i = 1'b0;
   logic       single_wr_i = 1'b0;
   logic       stop_i = 1'b0;
   logic [7:0] col_o;
   logic       beat_vld_o, last_o, cfg_err_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   burst_colgen #(.COL_W(8)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
      .len_code_i(len_code_i), .order_i(order_i), .is_write_i(is_write_i),
      .single_wr_i(single_wr_i), .stop_i(stop_i), .col_o(col_o),
      .beat_vld_o(beat_vld_o), .last_o(last_o), .cfg_err_o(cfg_err_o)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // expected length from the requirements; 256 stands for the endless page
   function automatic int mlen(input [2:0] code, input bit ord, input bit wr, input bit sw);
      if (wr && sw) return 1;
      case (code)
         3'b000: return 1;
         3'b001: return 2;
         3'b010: return 4;
         3'b011: return 8;
         3'b111: return ord ? 1 : 256;
         default: return 1;
      endcase
   endfunction

   function automatic bit mbad(input [2:0] code, input bit ord);
      return (code inside {3'b100, 3'b101, 3'b110}) || (code == 3'b111 && ord);
   endfunction

   function automatic logic [7:0] mcol(input logic [7:0] sc, input int len, input bit ord, input int k);
      logic [7:0] m;
      m = 8'(len - 1);
      if (ord) return sc ^ 8'(k);
      return (sc & ~m) | (8'(int'(sc) + k) & m);
   endfunction

   // {code, order, write, single_wr, start column}
   localparam int NV = 13;
   localparam logic [13:0] VEC [NV] = '{
      {3'b001, 1'b0, 1'b0, 1'b0, 8'h37},
      {3'b010, 1'b0, 1'b0, 1'b0, 8'h37},
      {3'b011, 1'b0, 1'b0, 1'b0, 8'h3D},
      {3'b011, 1'b1, 1'b0, 1'b0, 8'h3D},
      {3'b010, 1'b1, 1'b0, 1'b0, 8'hA6},
      {3'b001, 1'b1, 1'b0, 1'b0, 8'h11},
      {3'b000, 1'b0, 1'b0, 1'b0, 8'h80},
      {3'b011, 1'b0, 1'b1, 1'b1, 8'h45},
      {3'b011, 1'b0, 1'b0, 1'b1, 8'h45},
      {3'b011, 1'b0, 1'b1, 1'b0, 8'h45},
      {3'b100, 1'b0, 1'b0, 1'b0, 8'h12},
      {3'b111, 1'b1, 1'b0, 1'b0, 8'h22},
      {3'b110, 1'b1, 1'b0, 1'b0, 8'hFF}
   };

   task automatic issue(input [2:0] code, input bit ord, input bit wr, input bit sw, input [7:0] sc);
      start_i = 1'b1; len_code_i = code; order_i = ord;
      is_write_i = wr; single_wr_i = sw; start_col_i = sc;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic run_vec(input [2:0] code, input bit ord, input bit wr, input bit sw, input [7:0] sc);
      int    len;
      bit    bad;
      string tag;
      len = mlen(code, ord, wr, sw);
      bad = mbad(code, ord);
      if (bad)           tag = "R6";
      else if (wr && sw) tag = "R7";
      else if (ord)      tag = "R4";
      else               tag = "R3";
      issue(code, ord, wr, sw, sc);
      check(beat_vld_o && col_o == sc, "R1 first beat", int'(col_o), int'(sc));
      for (int k = 0; k < len; k++) begin
         check(beat_vld_o, {tag, " beat valid"}, int'(beat_vld_o), 1);
         check(col_o == mcol(sc, len, ord, k), {tag, " column"}, int'(col_o), int'(mcol(sc, len, ord, k)));
         check(last_o == (k == len - 1), "R2 last flag", int'(last_o), int'(k == len - 1));
         check(cfg_err_o == bad, "R6 error flag", int'(cfg_err_o), int'(bad));
         @(negedge clk);
      end
      check(!beat_vld_o, "R2 burst ended", int'(beat_vld_o), 0);
   endtask

   initial begin
      #(5.0 * 200000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset state
      check(!beat_vld_o && !last_o && !cfg_err_o && col_o == 8'h00, "R10 in reset",
            int'({beat_vld_o, last_o, cfg_err_o}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!beat_vld_o && col_o == 8'h00, "R10 after reset", int'(col_o), 0);

      for (int v = 0; v < NV; v++)
         run_vec(VEC[v][13:11], VEC[v][10], VEC[v][9], VEC[v][8], VEC[v][7:0]);

      // R6: error flag clears on the next valid start
      issue(3'b001, 1'b0, 1'b0, 1'b0, 8'h50);
      check(!cfg_err_o, "R6 flag cleared", int'(cfg_err_o), 0);
      @(negedge clk); @(negedge clk);

      // R5: whole page wraps past the top and never ends
      issue(3'b111, 1'b0, 1'b0, 1'b0, 8'hFE);
      for (int k = 0; k < 300; k++) begin
         check(beat_vld_o && !last_o && col_o == 8'(8'hFE + k), "R5 page column",
               int'(col_o), int'(8'(8'hFE + k)));
         @(negedge clk);
      end
      // R8: terminate the page burst
      stop_i = 1'b1;
      @(negedge clk);
      stop_i = 1'b0;
      check(!beat_vld_o, "R8 stop ends page burst", int'(beat_vld_o), 0);

      // R8: stop a finite burst partway
      issue(3'b011, 1'b0, 1'b0, 1'b0, 8'h40);
      @(negedge clk); @(negedge clk);
      check(beat_vld_o && col_o == 8'h42, "R3 before stop", int'(col_o), 8'h42);
      stop_i = 1'b1;
      @(negedge clk);
      stop_i = 1'b0;
      check(!beat_vld_o, "R8 stop mid burst", int'(beat_vld_o), 0);

      // R8: start wins over stop
      stop_i = 1'b1;
      issue(3'b001, 1'b0, 1'b0, 1'b0, 8'h91);
      stop_i = 1'b0;
      check(beat_vld_o && col_o == 8'h91, "R8 start beats stop", int'(col_o), 8'h91);
      @(negedge clk); @(negedge clk);

      // R9: restart during a burst
      issue(3'b011, 1'b0, 1'b0, 1'b0, 8'h10);
      @(negedge clk);
      check(col_o == 8'h11, "R9 old burst beat", int'(col_o), 8'h11);
      issue(3'b001, 1'b0, 1'b0, 1'b0, 8'h25);
      check(beat_vld_o && col_o == 8'h25 && !last_o, "R9 new burst beat 0", int'(col_o), 8'h25);
      @(negedge clk);
      check(beat_vld_o && col_o == 8'h24 && last_o, "R9 new burst beat 1", int'(col_o), 8'h24);
      @(negedge clk);
      check(!beat_vld_o, "R9 new burst ended", int'(beat_vld_o), 0);

      // R9: one-beat starts on every clock
      for (int k = 0; k < 5; k++) begin
         issue(3'b000, 1'b0, 1'b0, 1'b0, 8'(8'hC0 + 3 * k));
         check(beat_vld_o && last_o && col_o == 8'(8'hC0 + 3 * k), "R9 back to back",
               int'(col_o), int'(8'(8'hC0 + 3 * k)));
         start_i = 1'b1;
      end
      start_i = 1'b0;
      @(negedge clk);

      // R10: reset in the middle of a burst
      issue(3'b100, 1'b0, 1'b0, 1'b0, 8'h77);
      rst_n = 1'b0;
      @(negedge clk);
      check(!beat_vld_o && !cfg_err_o && !last_o && col_o == 8'h00, "R10 reset mid burst",
            int'(col_o), 0);
      rst_n = 1'b1;
      @(negedge clk);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule